// File: doc/BRIEF.md
# Bridge Secondary Error Status Register

This block holds the 16-bit secondary-side error status word of a virtual PCI-to-PCI bridge. Logic on the downstream link reports error conditions as single-cycle strobes. Each strobe sets one sticky flag, and some flags also depend on an enable bit taken from the bridge control register. A flag stays set until software writes a 1 to its bit position through a simple register port. That port carries a select (the address already matched), a write strobe, two byte enables and 16 bits of write data.

The read value is always available on `rdata`. It shows the current flags in their architectural bit positions, and every hardwired or reserved position reads as zero. Reading has no side effects. Decoding the register offset, parsing link packets and generating messages all happen outside this block.

Top module: `bridge_sec_errstat`

## Requirements
- R1: While `rst_n` is low, and on the first read after reset is released, `rdata` equals 16'h0000.
- R2: A pulse on `ev_poison_wr` (a poisoned posted write arrived from the link) sets bit 15 of `rdata` in the next cycle, with no enable.
- R3: A pulse on `ev_err_msg` (the secondary side sent a fatal or non-fatal error message) sets bit 14 in the next cycle only if `ctl_serr_en` is 1 in that cycle. Otherwise bit 14 keeps its value.
- R4: A pulse on `ev_cpl_unsup` (a completion with unsupported-request status for a request the bridge started) sets bit 13 in the next cycle.
- R5: A pulse on `ev_cpl_abort` (a completion with completer-abort status for a request the bridge started) sets bit 12 in the next cycle.
- R6: A pulse on `ev_poison_cpl` (a poisoned read-data completion arrived from the link) sets bit 8 in the next cycle only if `ctl_parity_en` is 1 in that cycle. Otherwise bit 8 keeps its value.
- R7: Bits 11, 10, 9, 7, 6, 5 and 4..0 always read 0, and writes to them have no effect.
- R8: A write (`cfg_sel`=1, `cfg_wr`=1, `cfg_be[1]`=1) clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged. The result is visible in the next cycle.
- R9: A write clears nothing if `cfg_sel` is 0, if `cfg_wr` is 0, or if `cfg_be[1]` is 0. `cfg_be[1]` covers bits 15..8, which hold every flag. `cfg_be[0]` covers bits 7..0, which hold no flag.
- R10: If a set event and a clear for the same flag arrive in the same cycle, the flag is 1 afterwards.
- R11: A set flag stays set when no clear reaches it, including when more events for it arrive.
- R12: With no event and no clearing write, `rdata` does not change from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_poison_wr | input | 1 | Strobe: poisoned posted write received |
| ev_err_msg | input | 1 | Strobe: fatal or non-fatal error message sent |
| ev_cpl_unsup | input | 1 | Strobe: unsupported-request completion received |
| ev_cpl_abort | input | 1 | Strobe: completer-abort completion received |
| ev_poison_cpl | input | 1 | Strobe: poisoned read completion received |
| ctl_serr_en | input | 1 | Bridge control system-error enable |
| ctl_parity_en | input | 1 | Bridge control parity-error enable |
| cfg_sel | input | 1 | Register port access targets this register |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_be | input | 2 | Byte enables, bit 1 for bits 15..8 |
| cfg_wdata | input | 16 | Write data, 1 = clear |
| rdata | output | 16 | Current register value |

## Verification
Every event strobe and every clearing write drives a flag register, so its effect shows on `rdata` exactly one cycle later. `rdata` is read combinationally from those registers and adds no further delay. The bench drives each stimulus on a falling edge, holds it across one rising edge and withdraws it. It then compares `rdata` at the next falling edge against a model word that it updates once for every such step. Steps with no stimulus check that `rdata` stays unchanged over the following cycles.

// File: rtl/sec_err_pkg.sv
package sec_err_pkg;

    localparam int REG_W    = 16;
    localparam int NBYTE    = REG_W / 8;
    localparam int NFLAG    = 5;

    // flag index order: poisoned write, error message, unsupported cpl,
    // completer abort cpl, poisoned read cpl
    localparam int IX_POISON_WR  = 0;
    localparam int IX_ERR_MSG    = 1;
    localparam int IX_CPL_UNSUP  = 2;
    localparam int IX_CPL_ABORT  = 3;
    localparam int IX_POISON_CPL = 4;

    function automatic int flag_pos(input int idx);
        case (idx)
            IX_POISON_WR:  return 15;
            IX_ERR_MSG:    return 14;
            IX_CPL_UNSUP:  return 13;
            IX_CPL_ABORT:  return 12;
            default:       return 8;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NFLAG; i++) m[flag_pos(i)] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } sticky_state_t;

endpackage

// File: rtl/sec_err_event_gate.sv
module sec_err_event_gate
    import sec_err_pkg::*;
(
    input  logic [NFLAG-1:0] ev,
    input  logic             serr_en,
    input  logic             parity_en,
    output logic [NFLAG-1:0] set_v
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_gate
        if (i == IX_ERR_MSG) begin : g_serr
            assign set_v[i] = ev[i] & serr_en;
        end else if (i == IX_POISON_CPL) begin : g_par
            assign set_v[i] = ev[i] & parity_en;
        end else begin : g_free
            assign set_v[i] = ev[i];
        end
    end
endmodule

// File: rtl/sec_err_clear_dec.sv
module sec_err_clear_dec
    import sec_err_pkg::*;
(
    input  logic             sel,
    input  logic             wr,
    input  logic [NBYTE-1:0] be,
    input  logic [REG_W-1:0] wdata,
    output logic [NFLAG-1:0] clr_v
);
    logic wr_hit;
    assign wr_hit = sel & wr;

    for (genvar i = 0; i < NFLAG; i++) begin : g_clr
        localparam int P = flag_pos(i);
        assign clr_v[i] = wr_hit & be[P/8] & wdata[P];
    end

    logic unused_bits;
    assign unused_bits = ^{be, wdata};
endmodule

// File: rtl/sec_err_sticky.sv
module sec_err_sticky
    import sec_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] clr_v,
    output logic [NFLAG-1:0] flags
);
    sticky_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over a same-cycle clear
        st_d.flags = (st_q.flags & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    for (genvar i = 0; i < NFLAG; i++) begin : g_chk
        // set beats clear
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> flags[i]);
        // no clear keeps a set flag
        assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_v[i]) |=> flags[i]);
        // write one clears
        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[i] && !set_v[i]) |=> !flags[i]);
        // nothing appears without a set
        assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !set_v[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/sec_err_read_pack.sv
module sec_err_read_pack
    import sec_err_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NFLAG; i++) rdata[flag_pos(i)] = flags[i];
    end
endmodule

// File: rtl/bridge_sec_errstat.sv
module bridge_sec_errstat
    import sec_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_poison_wr,
    input  logic             ev_err_msg,
    input  logic             ev_cpl_unsup,
    input  logic             ev_cpl_abort,
    input  logic             ev_poison_cpl,
    input  logic             ctl_serr_en,
    input  logic             ctl_parity_en,
    input  logic             cfg_sel,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_be,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      rdata
);
    localparam logic [REG_W-1:0] LIVE = live_mask();

    logic [NFLAG-1:0] ev_v, set_v, clr_v, flags;

    always_comb begin
        ev_v = '0;
        ev_v[IX_POISON_WR]  = ev_poison_wr;
        ev_v[IX_ERR_MSG]    = ev_err_msg;
        ev_v[IX_CPL_UNSUP]  = ev_cpl_unsup;
        ev_v[IX_CPL_ABORT]  = ev_cpl_abort;
        ev_v[IX_POISON_CPL] = ev_poison_cpl;
    end

    sec_err_event_gate u_gate (
        .ev        (ev_v),
        .serr_en   (ctl_serr_en),
        .parity_en (ctl_parity_en),
        .set_v     (set_v)
    );

    sec_err_clear_dec u_clr (
        .sel   (cfg_sel),
        .wr    (cfg_wr),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .clr_v (clr_v)
    );

    sec_err_sticky u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .flags (flags)
    );

    sec_err_read_pack u_pack (
        .flags (flags),
        .rdata (rdata)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));

    assert_serr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_serr_en && !rdata[14]) |=> !rdata[14]);

    assert_parity_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_parity_en && !rdata[8]) |=> !rdata[8]);

    assert_fixed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~LIVE) == '0);

    assert_no_clear_without_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_sel && cfg_wr && cfg_be[1])) |=> ((rdata & $past(rdata)) == $past(rdata)));
endmodule

// File: tb/test_bridge_sec_errstat.sv
module test_bridge_sec_errstat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ev = '0;
    logic        serr_en = 1'b0, par_en = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int tests = 0;
    int fails = 0;
    logic [15:0] model = '0;

    always #5 clk = ~clk;

    bridge_sec_errstat i_bridge_sec_errstat (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_poison_wr  (ev[4]),
        .ev_err_msg    (ev[3]),
        .ev_cpl_unsup  (ev[2]),
        .ev_cpl_abort  (ev[1]),
        .ev_poison_cpl (ev[0]),
        .ctl_serr_en   (serr_en),
        .ctl_parity_en (par_en),
        .cfg_sel       (sel),
        .cfg_wr        (wr),
        .cfg_be        (be),
        .cfg_wdata     (wdata),
        .rdata         (rdata)
    );

    task automatic check(input logic [15:0] exp, input string tag);
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
        end
    endtask

    // one stimulus cycle, driven at a falling edge, checked at the next
    task automatic step(input logic [4:0] e, input logic se, input logic pe,
                        input logic s, input logic w, input logic [1:0] b,
                        input logic [15:0] d, input string tag);
        logic [15:0] set_m, clr_m;
        set_m = '0;
        set_m[15] = e[4];
        set_m[14] = e[3] & se;
        set_m[13] = e[2];
        set_m[12] = e[1];
        set_m[8]  = e[0] & pe;
        clr_m = (s && w && b[1]) ? (d & 16'hF100) : 16'h0000;
        model = (model & ~clr_m) | set_m;
        ev = e; serr_en = se; par_en = pe;
        sel = s; wr = w; be = b; wdata = d;
        @(posedge clk);
        @(negedge clk);
        ev = '0; sel = 1'b0; wr = 1'b0; be = '0; wdata = '0;
        check(model, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(16'h0000, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(16'h0000, "R1 after reset");

        // R2 R3 R4 R5 R6: every event mix under every enable mix
        for (int e = 0; e < 32; e++) begin
            for (int en = 0; en < 4; en++) begin
                step(e[4:0], en[0], en[1], 0, 0, 2'b00, 16'h0, "R2 R3 R4 R5 R6 set");
                step('0, 0, 0, 1, 1, 2'b11, 16'hFFFF, "R8 clear all");
            end
        end

        // R7: writes to fixed bits do nothing
        step(5'b11111, 1, 1, 0, 0, 2'b00, 16'h0, "R7 setup");
        step('0, 0, 0, 1, 1, 2'b11, 16'h0EFF, "R7 fixed bits write");
        check(16'hF100, "R7 flags intact");
        step('0, 0, 0, 1, 1, 2'b11, 16'hFFFF, "R7 clear");
        step('0, 0, 0, 1, 1, 2'b11, 16'hFFFF, "R7 write ones to empty reg");

        // R8 R9: each flag, each qualifier combination
        for (int f = 0; f < 5; f++) begin
            for (int q = 0; q < 16; q++) begin
                logic [15:0] m;
                case (f)
                    0: m = 16'h8000;
                    1: m = 16'h4000;
                    2: m = 16'h2000;
                    3: m = 16'h1000;
                    default: m = 16'h0100;
                endcase
                step(5'b11111, 1, 1, 0, 0, 2'b00, 16'h0, "R8 R9 setup");
                step('0, 0, 0, q[0], q[1], q[3:2], m, "R8 R9 selective clear");
            end
        end
        step('0, 0, 0, 1, 1, 2'b11, 16'hFFFF, "R8 clear all");
        step(5'b11111, 1, 1, 0, 0, 2'b00, 16'h0, "R8 setup");
        step('0, 0, 0, 1, 1, 2'b11, 16'h0000, "R8 write zeros keeps");
        check(16'hF100, "R8 zeros keep flags");

        // R10: set and clear together
        step('0, 0, 0, 1, 1, 2'b11, 16'hFFFF, "R10 clear");
        step(5'b11111, 1, 1, 1, 1, 2'b11, 16'hFFFF, "R10 set wins");
        check(16'hF100, "R10 set wins value");

        // R11: repeated events on set flags
        step(5'b11111, 0, 0, 0, 0, 2'b00, 16'h0, "R11 repeat events");
        check(16'hF100, "R11 still set");

        // R12: idle cycles keep value
        for (int k = 0; k < 4; k++) step('0, 0, 0, 0, 0, 2'b00, 16'h0, "R12 idle stable");
        step('0, 0, 0, 1, 1, 2'b11, 16'h3000, "R12 partial clear");
        for (int k = 0; k < 3; k++) step('0, 1, 1, 1, 0, 2'b11, 16'hFFFF, "R12 read only");
        check(16'hC100, "R12 final value");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule